// File: doc/BRIEF.md
# Registered inverting bus transceiver

This block connects two 8-bit buses, A and B, in both directions. Each direction has its own storage register with its own capture clock. The A-to-B register samples bus A and the B-to-A register samples bus B. Two enable controls decide which bus, if either, the block drives. Two source selects decide, separately for each direction, whether a driven bus carries the live opposite bus or the stored register. Every driven value is the bitwise inverse of its source. The exception is the hold mode described below.

Each bus is modelled as an input vector, an output vector and an output-enable. Drive is a single enable per bus, and no tri-state pads are needed.

When both buses are driven and both selects choose the live path, the buses would just reinforce each other. The block models this as a bus-hold: each bus keeps the value it had at the last rise of the system clock before the mode was entered.

Top module: `inv_regxcvr`

## Requirements
- R1: A rising edge of `clk_ab` loads `a_in` into the A-to-B register. A rising edge of `clk_ba` loads `b_in` into the B-to-A register.
- R2: A register load happens whatever the values of `drv_b`, `drv_a_n`, `src_b_reg` and `src_a_reg`. This includes the case where neither bus is driven.
- R3: `src_b_reg`=0 selects live `a_in` as the source for bus B, and `src_b_reg`=1 selects the A-to-B register. `src_a_reg` selects between live `b_in` (0) and the B-to-A register (1) for bus A.
- R4: With `drv_b`=0 and `drv_a_n`=1, both `a_oe` and `b_oe` are 0.
- R5: `b_oe` is 1 exactly when `drv_b`=1. `a_oe` is 1 exactly when `drv_a_n`=0. Both may be 1 at once.
- R6: Outside hold mode, a driven output equals the bitwise inverse of its selected source.
- R7: With both buses driven and both selects at 1, `a_out` equals the inverse of the B-to-A register and `b_out` equals the inverse of the A-to-B register.
- R8: Hold mode is `drv_b`=1, `drv_a_n`=0, `src_b_reg`=0 and `src_a_reg`=0. In hold mode, `a_out` and `b_out` equal the values of `a_in` and `b_in`, not inverted, taken at the last `clk` rise before the mode was entered. These values do not change while the mode lasts.
- R9: `rst_n` low clears both registers and the hold values to 0.
- R10: Output values are combinational. A live change of `a_in` or `b_in` shows at once, and a register load shows right after its clock edge, with no `clk` edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus-hold capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| drv_b | input | 1 | 1 = drive bus B |
| drv_a_n | input | 1 | 0 = drive bus A |
| src_b_reg | input | 1 | Bus B source: 0 live A, 1 A-to-B register |
| src_a_reg | input | 1 | Bus A source: 0 live B, 1 B-to-A register |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Bus B drive enable |

## Verification
The main loop walks all 64 combinations of the four static controls and the two register clock pulses. Data come from a table of eight patterns chosen so that no bit pattern matches its own inverse or the other bus. This tells the live path, the stored path and a missing inversion apart on every step.

Directed tests load a register while neither bus is driven and then reveal it, which separates capture from the enables. They change the input buses after hold mode is entered to show the held values are frozen. They also check the outputs right after a register clock edge, which catches any extra register stage.

// File: rtl/inv_regxcvr_pkg.sv
package inv_regxcvr_pkg;
  typedef enum logic [1:0] {
    SRC_LIVE   = 2'd0,
    SRC_STORED = 2'd1,
    SRC_HOLD   = 2'd2
  } src_e;
endpackage

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R1: the register holds what its input showed at the previous edge
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> q == $past(d));
endmodule

// File: rtl/bus_hold.sv
module bus_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] hold_a,
  output logic [W-1:0] hold_b
);
  logic [W-1:0] hold_a_nxt, hold_b_nxt;
  logic         upd_en;

  always_comb begin
    upd_en     = !freeze;
    hold_a_nxt = upd_en ? a_in : hold_a;
    hold_b_nxt = upd_en ? b_in : hold_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      hold_a <= hold_a_nxt;
      hold_b <= hold_b_nxt;
    end
  end

  // R8: held values never move while frozen
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (hold_a == $past(hold_a)) && (hold_b == $past(hold_b)));
endmodule

// File: rtl/inv_regxcvr.sv
module inv_regxcvr
  import inv_regxcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         drv_b,
  input  logic         drv_a_n,
  input  logic         src_b_reg,
  input  logic         src_a_reg,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] ab_q, ba_q, hold_a, hold_b;
  logic         hold_mode;
  src_e         src_a, src_b;

  xfer_reg #(.W(W)) u_ab_reg (.clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(ab_q));
  xfer_reg #(.W(W)) u_ba_reg (.clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(ba_q));

  always_comb begin
    hold_mode = drv_b && !drv_a_n && !src_b_reg && !src_a_reg;
  end

  bus_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .freeze(hold_mode),
    .a_in(a_in), .b_in(b_in), .hold_a(hold_a), .hold_b(hold_b)
  );

  always_comb begin
    if (hold_mode) begin
      src_a = SRC_HOLD;
      src_b = SRC_HOLD;
    end else begin
      src_a = src_a_reg ? SRC_STORED : SRC_LIVE;
      src_b = src_b_reg ? SRC_STORED : SRC_LIVE;
    end
  end

  always_comb begin
    a_oe = !drv_a_n;
    b_oe = drv_b;
    unique case (src_a)
      SRC_STORED: a_out = ~ba_q;
      SRC_HOLD:   a_out = hold_a;
      default:    a_out = ~b_in;
    endcase
    unique case (src_b)
      SRC_STORED: b_out = ~ab_q;
      SRC_HOLD:   b_out = hold_b;
      default:    b_out = ~a_in;
    endcase
  end

  // R4: idle controls leave both buses undriven
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_b && drv_a_n) |-> (!a_oe && !b_oe));

  // R6: live path on B is the inverse of bus A
  p_live_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !src_b_reg && !hold_mode) |-> (b_out == ~a_in));

  // R7: both driven from storage, crossed and inverted
  p_stored_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && b_oe && src_a_reg && src_b_reg) |-> (a_out == ~ba_q && b_out == ~ab_q));

  // R8: outputs steady across consecutive hold-mode cycles
  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_mode |=> (!hold_mode || ($stable(a_out) && $stable(b_out))));
endmodule

// File: tb/inv_regxcvr_bench.sv
module inv_regxcvr_bench;
  localparam int W = 8;
  localparam int PERIOD = 10;
  localparam logic [15:0] PAT [8] = '{
    16'h5A_C3, 16'h0F_96, 16'hE1_3C, 16'h7B_12,
    16'hA4_D8, 16'h69_F0, 16'h1E_87, 16'hB2_4D
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic drv_b = 1'b0, drv_a_n = 1'b1, src_b_reg = 1'b0, src_a_reg = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab = '0, m_ba = '0, m_ha = '0, m_hb = '0;

  inv_regxcvr #(.W(W)) u_inv_regxcvr (
    .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .drv_b(drv_b), .drv_a_n(drv_a_n), .src_b_reg(src_b_reg), .src_a_reg(src_a_reg),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic bit in_hold();
    return drv_b && !drv_a_n && !src_b_reg && !src_a_reg;
  endfunction

  // reference hold values: last bus values at a clk rise outside hold mode
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ha <= '0;
      m_hb <= '0;
    end else if (!in_hold()) begin
      m_ha <= a_in;
      m_hb <= b_in;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    clk_ab = 1'b1; m_ab = a_in; #1; clk_ab = 1'b0; #1;
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1; m_ba = b_in; #1; clk_ba = 1'b0; #1;
  endtask

  task automatic check_all();
    logic [W-1:0] ea, eb;
    string ta, tb;
    chk("R5 a_oe", {7'd0, a_oe}, {7'd0, !drv_a_n});
    chk("R5 b_oe", {7'd0, b_oe}, {7'd0, drv_b});
    if (in_hold()) begin
      ea = m_ha; eb = m_hb; ta = "R8 a_out"; tb = "R8 b_out";
    end else begin
      ea = src_a_reg ? ~m_ba : ~b_in;
      eb = src_b_reg ? ~m_ab : ~a_in;
      ta = (src_a_reg && src_b_reg && a_oe && b_oe) ? "R7 a_out" : "R3/R6 a_out";
      tb = (src_a_reg && src_b_reg && a_oe && b_oe) ? "R7 b_out" : "R3/R6 b_out";
    end
    if (!drv_a_n) chk(ta, a_out, ea);
    if (drv_b)    chk(tb, b_out, eb);
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R4 idle a_oe", {7'd0, a_oe}, 8'd0);
    chk("R4 idle b_oe", {7'd0, b_oe}, 8'd0);
    drv_b = 1'b1; src_b_reg = 1'b1; drv_a_n = 1'b0; src_a_reg = 1'b1; #1;
    chk("R9 ab cleared", b_out, 8'hFF);
    chk("R9 ba cleared", a_out, 8'hFF);
    rst_n = 1'b1;
    drv_b = 1'b0; drv_a_n = 1'b1; src_b_reg = 1'b0; src_a_reg = 1'b0;

    // table walk: all 64 combinations of four controls and two clock pulses
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      {a_in, b_in} = PAT[i % 8] ^ {i[7:0], 8'h00};
      {drv_b, drv_a_n, src_b_reg, src_a_reg} = i[3:0];
      #1;
      if (i[4]) pulse_ab();
      if (i[5]) pulse_ba();
      check_all();
    end

    // R2: store while idle, then reveal
    @(negedge clk);
    drv_b = 1'b0; drv_a_n = 1'b1; src_b_reg = 1'b1; src_a_reg = 1'b1;
    a_in = 8'h5A; b_in = 8'h3C; #1;
    pulse_ab(); pulse_ba();
    chk("R2 idle a_oe", {7'd0, a_oe}, 8'd0);
    a_in = 8'h00; b_in = 8'h00;
    drv_b = 1'b1; drv_a_n = 1'b0; #1;
    chk("R2 R1 ab stored", b_out, 8'hA5);
    chk("R2 R1 ba stored", a_out, 8'hC3);

    // R10: new load visible straight after its edge, no clk edge between
    a_in = 8'h81; #1;
    pulse_ab();
    chk("R10 ab same cycle", b_out, 8'h7E);
    src_b_reg = 1'b0; #1;
    chk("R10 live path", b_out, 8'h7E);
    a_in = 8'h42; #1;
    chk("R10 live change", b_out, 8'hBD);

    // R8: enter hold mode, then change inputs
    @(negedge clk);
    drv_b = 1'b0; drv_a_n = 1'b1; src_a_reg = 1'b0;
    a_in = 8'h96; b_in = 8'h2D;
    @(negedge clk);
    drv_b = 1'b1; drv_a_n = 1'b0; #1;
    chk("R8 hold a", a_out, 8'h96);
    chk("R8 hold b", b_out, 8'h2D);
    a_in = 8'h11; b_in = 8'hEE;
    repeat (3) @(negedge clk);
    chk("R8 frozen a", a_out, 8'h96);
    chk("R8 frozen b", b_out, 8'h2D);
    src_b_reg = 1'b1; #1;
    chk("R8 exit b", b_out, 8'h7E);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule